// File: doc/BRIEF.md
# Submission Queue Doorbell Fetch Engine

This block is the device-side front end of a storage controller command path that runs without firmware. The host tells the device about new commands only by writing a new tail index into a per-queue doorbell register. The block keeps a device-side head index for each submission queue. Whenever a queue's tail differs from its head, the queue is pending. The engine then fetches one 64-byte submission entry from host memory, decodes it and passes the command downstream. No processor polls anything in this path.

Pending queues are served in round-robin order, one entry per grant. Each fetch is a single read request at `base + head * 64`. The host answers the request with `512 / DATA_W` data beats, sent in order. The engine advances the head, which wraps to zero at the configured queue size, when the memory side accepts the request. The engine splits the assembled entry into its command fields and presents them on a valid/ready port, together with the ID of the queue the entry came from. Queue base addresses and sizes come from configuration inputs. A doorbell write with a tail index outside the queue is dropped and flagged.

Top module: `sqf_fetch_engine`

## Requirements
- R1: While reset is held, and after its release, `rd_req_valid`, `cmd_valid` and `db_err` are 0 and every head index on `sq_head` is 0.
- R2: A doorbell write with tail below the queue size makes the queue pending. The engine then issues a read at `cfg_sq_base[q] + head*64`, and this address always has its low 6 bits at zero.
- R3: A doorbell write whose tail is at or above the queue size, or whose queue ID does not exist, changes no state and starts no fetch. `db_err` is 1 for exactly the one cycle after that write.
- R4: A head index advances by one per accepted read request. After reaching size-1 it goes back to 0, and it never reaches the queue size.
- R5: Pending queues are granted round-robin, starting after the queue granted last, one entry per grant. At most one queue is granted per cycle.
- R6: `rd_req_valid` and `rd_req_addr` stay unchanged until `rd_req_ready` is seen high.
- R7: The entry is built from `512/DATA_W` response beats, lowest bytes first, and idle cycles between beats are allowed. Fields are taken by doubleword (dw): opcode = dw0[7:0], command ID = dw0[31:16], namespace = dw1, PRP1 = {dw7,dw6}, PRP2 = {dw9,dw8}, starting LBA = {dw11,dw10}, block count = dw12[15:0].
- R8: A presented command and its queue ID stay unchanged until `cmd_ready`, and no new read is issued before it is taken.
- R9: A tail that moves forward by N yields N fetches in rising index order. Doorbell writes that arrive while a fetch is under way are kept and served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_valid | input | 1 | Doorbell write strobe |
| db_wr_qid | input | QID_W | Queue whose tail doorbell is written |
| db_wr_tail | input | IDX_W | New tail index |
| db_err | output | 1 | Pulse: last doorbell write was rejected |
| cfg_sq_base | input | NUM_Q*64 | Per-queue base address, 64-byte aligned |
| cfg_sq_size | input | NUM_Q*IDX_W | Per-queue entry count (at least 2) |
| sq_head | output | NUM_Q*IDX_W | Current head index of every queue |
| rd_req_valid | output | 1 | Entry read request valid |
| rd_req_ready | input | 1 | Memory side accepts the request |
| rd_req_addr | output | 64 | Byte address of the entry |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | DATA_W | Response beat data |
| cmd_valid | output | 1 | Decoded command valid |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_qid | output | QID_W | Source queue |
| cmd_opcode | output | 8 | Opcode |
| cmd_cid | output | 16 | Command identifier |
| cmd_nsid | output | 32 | Namespace |
| cmd_slba | output | 64 | Starting LBA |
| cmd_nlb | output | 16 | Block count field |
| cmd_prp1 | output | 64 | First data pointer |
| cmd_prp2 | output | 64 | Second data pointer or list pointer |

## Verification
The bench builds the engine with four queues, a 4-bit index and 128-bit response beats, so every entry arrives as four beats. With a 4-bit index, tail values at and above the queue size are easy to drive, which tests the reject path. Queue 2 is set to four entries, so its head wraps after a few fetches. Memory stalls held during a burst of doorbell writes fix which queues are pending together, so the round-robin order can be predicted. Downstream back-pressure and idle cycles between response beats exercise the hold rules.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

  localparam int SQF_ADDR_W    = 64;
  localparam int SQF_ENTRY_W   = 512;
  localparam int SQF_ENTRY_LG2 = 6;
  localparam int SQF_IDXF_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_OUT  = 2'd3
  } sqf_state_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [15:0] cid;
    logic [31:0] nsid;
    logic [63:0] slba;
    logic [15:0] nlb;
    logic [63:0] prp1;
    logic [63:0] prp2;
  } sqf_cmd_t;

  // byte address of slot idx in a queue starting at base
  function automatic logic [SQF_ADDR_W-1:0] slot_addr(
      input logic [SQF_ADDR_W-1:0] base, input logic [SQF_IDXF_W-1:0] idx);
    logic [SQF_ADDR_W-1:0] off;
    off = SQF_ADDR_W'(idx) << SQF_ENTRY_LG2;
    return base + off;
  endfunction

  // ring increment: size-1 goes back to zero
  function automatic logic [SQF_IDXF_W-1:0] ring_step(
      input logic [SQF_IDXF_W-1:0] idx, input logic [SQF_IDXF_W-1:0] depth);
    logic [SQF_IDXF_W:0] nxt;
    nxt = {1'b0, idx} + 1'b1;
    return (nxt >= {1'b0, depth}) ? '0 : nxt[SQF_IDXF_W-1:0];
  endfunction

  function automatic logic [31:0] dw_of(input logic [SQF_ENTRY_W-1:0] e, input int n);
    return e[32*n +: 32];
  endfunction

  function automatic sqf_cmd_t decode_entry(input logic [SQF_ENTRY_W-1:0] e);
    sqf_cmd_t c;
    logic [31:0] d0;
    logic [31:0] d12;
    d0       = dw_of(e, 0);
    d12      = dw_of(e, 12);
    c.opcode = d0[7:0];
    c.cid    = d0[31:16];
    c.nsid   = dw_of(e, 1);
    c.prp1   = {dw_of(e, 7), dw_of(e, 6)};
    c.prp2   = {dw_of(e, 9), dw_of(e, 8)};
    c.slba   = {dw_of(e, 11), dw_of(e, 10)};
    c.nlb    = d12[15:0];
    return c;
  endfunction

endpackage

// File: rtl/sqf_db_bank.sv
module sqf_db_bank #(
  parameter int NUM_Q = 4,
  parameter int IDX_W = 8,
  parameter int QID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [QID_W-1:0]       wr_qid,
  input  logic [IDX_W-1:0]       wr_tail,
  input  logic [NUM_Q*IDX_W-1:0] cfg_size,
  input  logic                   adv_valid,
  input  logic [QID_W-1:0]       adv_qid,
  output logic [NUM_Q*IDX_W-1:0] head_flat,
  output logic [NUM_Q-1:0]       pending,
  output logic                   good_evt,
  output logic                   bad_evt,
  output logic                   err_pulse
);
  import sqf_pkg::*;

  logic [IDX_W-1:0] sel_size;
  logic             qid_ok;

  always_comb begin
    sel_size = '0;
    qid_ok   = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (wr_qid == QID_W'(q)) begin
        sel_size = cfg_size[q*IDX_W +: IDX_W];
        qid_ok   = 1'b1;
      end
    end
  end

  assign bad_evt  = wr_valid && (!qid_ok || (wr_tail >= sel_size));
  assign good_evt = wr_valid && !bad_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= bad_evt;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [IDX_W-1:0] tail_r;
    logic [IDX_W-1:0] head_r;
    logic [IDX_W-1:0] head_nx;

    assign head_nx = IDX_W'(ring_step(SQF_IDXF_W'(head_r),
                                      SQF_IDXF_W'(cfg_size[q*IDX_W +: IDX_W])));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tail_r <= '0;
        head_r <= '0;
      end else begin
        if (good_evt && wr_qid == QID_W'(q)) tail_r <= wr_tail;
        if (adv_valid && adv_qid == QID_W'(q)) head_r <= head_nx;
      end
    end

    assign pending[q]                  = (tail_r != head_r);
    assign head_flat[q*IDX_W +: IDX_W] = head_r;
  end
endmodule

// File: rtl/sqf_rr_arb.sv
module sqf_rr_arb #(
  parameter int NUM_Q = 4,
  parameter int QID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] req,
  input  logic             take,
  output logic [NUM_Q-1:0] grant,
  output logic [QID_W-1:0] grant_idx,
  output logic             any
);
  logic [QID_W-1:0] last_q;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int i = 1; i <= NUM_Q; i++) begin
      int c;
      c = (int'(last_q) + i) % NUM_Q;
      if (!any && req[c]) begin
        any       = 1'b1;
        grant[c]  = 1'b1;
        grant_idx = QID_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           last_q <= QID_W'(NUM_Q - 1);
    else if (take && any) last_q <= grant_idx;
  end
endmodule

// File: rtl/sqf_entry_asm.sv
module sqf_entry_asm #(
  parameter int DATA_W = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           beat_valid,
  input  logic [DATA_W-1:0]              beat_data,
  output logic [sqf_pkg::SQF_ENTRY_W-1:0] entry,
  output logic                           full
);
  import sqf_pkg::*;

  localparam int BEATS = SQF_ENTRY_W / DATA_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      full  <= 1'b0;
      entry <= '0;
    end else if (start) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (beat_valid && !full) begin
      entry[int'(cnt)*DATA_W +: DATA_W] <= beat_data;
      if (int'(cnt) == BEATS - 1) full <= 1'b1;
      else                        cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sqf_fetch_engine.sv
module sqf_fetch_engine #(
  parameter int NUM_Q  = 4,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 128,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   db_wr_valid,
  input  logic [QID_W-1:0]       db_wr_qid,
  input  logic [IDX_W-1:0]       db_wr_tail,
  output logic                   db_err,
  input  logic [NUM_Q*64-1:0]    cfg_sq_base,
  input  logic [NUM_Q*IDX_W-1:0] cfg_sq_size,
  output logic [NUM_Q*IDX_W-1:0] sq_head,
  output logic                   rd_req_valid,
  input  logic                   rd_req_ready,
  output logic [63:0]            rd_req_addr,
  input  logic                   rd_rsp_valid,
  input  logic [DATA_W-1:0]      rd_rsp_data,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [QID_W-1:0]       cmd_qid,
  output logic [7:0]             cmd_opcode,
  output logic [15:0]            cmd_cid,
  output logic [31:0]            cmd_nsid,
  output logic [63:0]            cmd_slba,
  output logic [15:0]            cmd_nlb,
  output logic [63:0]            cmd_prp1,
  output logic [63:0]            cmd_prp2
);
  import sqf_pkg::*;

  sqf_state_e             state;
  logic [QID_W-1:0]       cur_q;
  logic [63:0]            cur_addr;

  // named internal events
  logic                   db_fetch_evt;
  logic                   db_bad_evt;
  logic [NUM_Q-1:0]       pend_vec;
  logic [NUM_Q-1:0]       arb_grant;
  logic [QID_W-1:0]       arb_idx;
  logic                   arb_any;
  logic                   arb_take;
  logic                   fetch_accept;
  logic                   asm_full;
  logic [SQF_ENTRY_W-1:0] entry_q;
  logic [63:0]            grant_base;
  logic [IDX_W-1:0]       grant_head;
  sqf_cmd_t               dec;

  assign arb_take     = (state == ST_IDLE) && arb_any;
  assign fetch_accept = (state == ST_REQ) && rd_req_ready;

  sqf_db_bank #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .QID_W(QID_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(db_wr_valid), .wr_qid(db_wr_qid), .wr_tail(db_wr_tail),
    .cfg_size(cfg_sq_size),
    .adv_valid(fetch_accept), .adv_qid(cur_q),
    .head_flat(sq_head), .pending(pend_vec),
    .good_evt(db_fetch_evt), .bad_evt(db_bad_evt), .err_pulse(db_err)
  );

  sqf_rr_arb #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend_vec), .take(arb_take),
    .grant(arb_grant), .grant_idx(arb_idx), .any(arb_any)
  );

  sqf_entry_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .start(fetch_accept),
    .beat_valid(rd_rsp_valid && state == ST_DATA), .beat_data(rd_rsp_data),
    .entry(entry_q), .full(asm_full)
  );

  always_comb begin
    grant_base = '0;
    grant_head = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (arb_grant[q]) begin
        grant_base = cfg_sq_base[q*64 +: 64];
        grant_head = sq_head[q*IDX_W +: IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_q    <= '0;
      cur_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (arb_any) begin
          cur_q    <= arb_idx;
          cur_addr <= slot_addr(grant_base, SQF_IDXF_W'(grant_head));
          state    <= ST_REQ;
        end
        ST_REQ:  if (rd_req_ready) state <= ST_DATA;
        ST_DATA: if (asm_full) state <= ST_OUT;
        ST_OUT:  if (cmd_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dec          = decode_entry(entry_q);
  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_addr  = cur_addr;
  assign cmd_valid    = (state == ST_OUT);
  assign cmd_qid      = cur_q;
  assign cmd_opcode   = dec.opcode;
  assign cmd_cid      = dec.cid;
  assign cmd_nsid     = dec.nsid;
  assign cmd_slba     = dec.slba;
  assign cmd_nlb      = dec.nlb;
  assign cmd_prp1     = dec.prp1;
  assign cmd_prp2     = dec.prp2;
endmodule

// File: rtl/sqf_checker.sv
module sqf_checker #(
  parameter int NUM_Q = 4,
  parameter int IDX_W = 8,
  parameter int QID_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   db_bad_evt,
  input logic                   db_err,
  input logic [NUM_Q-1:0]       arb_grant,
  input logic [NUM_Q*IDX_W-1:0] sq_head,
  input logic [NUM_Q*IDX_W-1:0] cfg_sq_size,
  input logic                   rd_req_valid,
  input logic                   rd_req_ready,
  input logic [63:0]            rd_req_addr,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic [QID_W-1:0]       cmd_qid,
  input logic [63:0]            cmd_slba,
  input logic [15:0]            cmd_cid
);
  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    db_bad_evt |=> db_err);

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !db_bad_evt |=> !db_err);

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_req_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[5:0] == 6'd0);

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_qid)
      && $stable(cmd_slba) && $stable(cmd_cid));

  assert_no_req_with_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rd_req_valid));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_hd
    assert_head_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sq_head[q*IDX_W +: IDX_W] < cfg_sq_size[q*IDX_W +: IDX_W]);
  end
endmodule

bind sqf_fetch_engine sqf_checker #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .QID_W(QID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_bad_evt(db_bad_evt), .db_err(db_err),
  .arb_grant(arb_grant), .sq_head(sq_head), .cfg_sq_size(cfg_sq_size),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_qid(cmd_qid),
  .cmd_slba(cmd_slba), .cmd_cid(cmd_cid)
);

// File: tb/sqf_fetch_engine_bench.sv
module sqf_fetch_engine_bench;
  localparam int NQ = 4;
  localparam int IW = 4;
  localparam int DW = 128;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             db_wr_valid = 1'b0;
  logic [QW-1:0]    db_wr_qid = '0;
  logic [IW-1:0]    db_wr_tail = '0;
  logic             db_err;
  logic [NQ*64-1:0] cfg_sq_base;
  logic [NQ*IW-1:0] cfg_sq_size;
  logic [NQ*IW-1:0] sq_head;
  logic             rd_req_valid;
  logic             rd_req_ready = 1'b0;
  logic [63:0]      rd_req_addr;
  logic             rd_rsp_valid = 1'b0;
  logic [DW-1:0]    rd_rsp_data = '0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b0;
  logic [QW-1:0]    cmd_qid;
  logic [7:0]       cmd_opcode;
  logic [15:0]      cmd_cid;
  logic [31:0]      cmd_nsid;
  logic [63:0]      cmd_slba;
  logic [15:0]      cmd_nlb;
  logic [63:0]      cmd_prp1;
  logic [63:0]      cmd_prp2;

  sqf_fetch_engine #(.NUM_Q(NQ), .IDX_W(IW), .DATA_W(DW)) u_sqf_fetch_engine (.*);

  int checks = 0;
  int errors = 0;

  logic [63:0] qbase [NQ];
  int          qsize [NQ];

  // memory / sink control and logs
  bit          mem_hold = 1'b0;
  bit          gap_en = 1'b0;
  bit          sink_en = 1'b1;
  int          req_n = 0;
  logic [63:0] req_log [64];
  int          cmd_n = 0;
  logic [QW-1:0] lq [64];
  logic [7:0]  lop [64];
  logic [15:0] lcid [64];
  logic [31:0] lns [64];
  logic [63:0] lslba [64];
  logic [15:0] lnlb [64];
  logic [63:0] lp1 [64];
  logic [63:0] lp2 [64];

  int exp_q [64];
  int exp_i [64];
  int exp_n = 0;

  function automatic logic [31:0] mdw(input logic [63:0] a, input int i);
    return a[31:0] + 32'h0101_0000 * i + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
      if (rd_req_valid && !mem_hold) begin
        logic [63:0] a;
        a = rd_req_addr;
        rd_req_ready = 1'b1;
        if (req_n < 64) req_log[req_n] = a;
        req_n++;
        @(negedge clk);
        rd_req_ready = 1'b0;
        for (int k = 0; k < 4; k++) begin
          if (gap_en) begin
            rd_rsp_valid = 1'b0;
            @(negedge clk);
          end
          rd_rsp_valid = 1'b1;
          for (int j = 0; j < 4; j++) rd_rsp_data[32*j +: 32] = mdw(a, 4*k + j);
          @(negedge clk);
        end
        rd_rsp_valid = 1'b0;
      end
    end
  end

  // command sink
  initial begin
    forever begin
      @(negedge clk);
      cmd_ready = sink_en;
      if (cmd_valid && cmd_ready && rst_n) begin
        if (cmd_n < 64) begin
          lq[cmd_n] = cmd_qid; lop[cmd_n] = cmd_opcode; lcid[cmd_n] = cmd_cid;
          lns[cmd_n] = cmd_nsid; lslba[cmd_n] = cmd_slba; lnlb[cmd_n] = cmd_nlb;
          lp1[cmd_n] = cmd_prp1; lp2[cmd_n] = cmd_prp2;
        end
        cmd_n++;
      end
    end
  end

  task automatic ring(input int q, input int t, output logic err);
    @(negedge clk);
    db_wr_valid = 1'b1;
    db_wr_qid   = QW'(q);
    db_wr_tail  = IW'(t);
    @(negedge clk);
    db_wr_valid = 1'b0;
    err = db_err;
  endtask

  task automatic expect_cmd(input int q, input int idx);
    exp_q[exp_n] = q;
    exp_i[exp_n] = idx;
    exp_n++;
  endtask

  task automatic wait_cmds(input int n, input string rq);
    int t = 0;
    while (cmd_n < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(cmd_n >= n, rq, "command count", 64'(cmd_n), 64'(n));
  endtask

  task automatic verify_range(input int from, input int to, input string rq);
    for (int k = from; k < to; k++) begin
      logic [63:0] a;
      a = qbase[exp_q[k]] + 64'(exp_i[k]) * 64;
      chk(req_log[k] == a, "R2", "read address", req_log[k], a);
      chk(lq[k] == QW'(exp_q[k]), rq, "queue order", 64'(lq[k]), 64'(exp_q[k]));
      chk(lop[k] == mdw(a, 0) >> 0 & 8'hFF || lop[k] == mdw(a, 0)[7:0], "R7", "opcode",
          64'(lop[k]), 64'(mdw(a, 0) & 32'hFF));
      chk(lcid[k] == mdw(a, 0) >> 16, "R7", "cid", 64'(lcid[k]), 64'(mdw(a, 0) >> 16));
      chk(lns[k] == mdw(a, 1), "R7", "nsid", 64'(lns[k]), 64'(mdw(a, 1)));
      chk(lp1[k] == {mdw(a, 7), mdw(a, 6)}, "R7", "prp1", lp1[k], {mdw(a, 7), mdw(a, 6)});
      chk(lp2[k] == {mdw(a, 9), mdw(a, 8)}, "R7", "prp2", lp2[k], {mdw(a, 9), mdw(a, 8)});
      chk(lslba[k] == {mdw(a, 11), mdw(a, 10)}, "R7", "slba", lslba[k], {mdw(a, 11), mdw(a, 10)});
      chk(lnlb[k] == mdw(a, 12) % 65536, "R7", "nlb", 64'(lnlb[k]), 64'(mdw(a, 12) % 65536));
    end
  endtask

  function automatic int head_of(input int q);
    return int'(sq_head[q*IW +: IW]);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(!rd_req_valid, "R1", "rd_req_valid in reset", 64'(rd_req_valid), 0);
    chk(!cmd_valid, "R1", "cmd_valid in reset", 64'(cmd_valid), 0);
    chk(sq_head == '0, "R1", "heads in reset", 64'(sq_head), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && !cmd_valid && !db_err, "R1", "idle after reset",
        {61'd0, rd_req_valid, cmd_valid, db_err}, 0);
  endtask

  task automatic t_single;
    logic e;
    int base = exp_n;
    ring(0, 1, e);
    chk(!e, "R3", "no error on valid doorbell", 64'(e), 0);
    expect_cmd(0, 0);
    wait_cmds(exp_n, "R2");
    verify_range(base, exp_n, "R2");
    chk(head_of(0) == 1, "R2", "head q0 after one fetch", 64'(head_of(0)), 1);
  endtask

  task automatic t_bad;
    logic e;
    int r0 = req_n;
    ring(1, qsize[1], e);
    chk(e, "R3", "db_err after tail == size", 64'(e), 1);
    @(negedge clk);
    chk(!db_err, "R3", "db_err one cycle only", 64'(db_err), 0);
    ring(3, 15, e);
    chk(e, "R3", "db_err after tail beyond size", 64'(e), 1);
    repeat (20) @(negedge clk);
    chk(req_n == r0, "R3", "no fetch after rejected write", 64'(req_n), 64'(r0));
    chk(head_of(1) == 0 && head_of(3) == 0, "R3", "heads unchanged",
        64'(sq_head), 64'(head_of(0)));
  endtask

  task automatic t_wrap;
    logic e;
    int base = exp_n;
    ring(2, 3, e);
    for (int i = 0; i < 3; i++) expect_cmd(2, i);
    wait_cmds(exp_n, "R9");
    ring(2, 1, e);
    expect_cmd(2, 3);
    expect_cmd(2, 0);
    wait_cmds(exp_n, "R4");
    verify_range(base, exp_n, "R9");
    chk(head_of(2) == 1, "R4", "head q2 wrapped", 64'(head_of(2)), 1);
  endtask

  task automatic t_rr;
    logic e;
    int base = exp_n;
    mem_hold = 1'b1;
    sink_en  = 1'b0;
    gap_en   = 1'b1;
    ring(0, 3, e);
    ring(1, 2, e);
    ring(3, 2, e);
    repeat (6) @(negedge clk);
    mem_hold = 1'b0;
    repeat (12) @(negedge clk);
    chk(req_n == base + 1, "R8", "no new read while command waits", 64'(req_n), 64'(base + 1));
    sink_en = 1'b1;
    expect_cmd(0, 1); expect_cmd(1, 0); expect_cmd(3, 0);
    expect_cmd(0, 2); expect_cmd(1, 1); expect_cmd(3, 1);
    wait_cmds(exp_n, "R5");
    verify_range(base, exp_n, "R5");
    chk(head_of(0) == 3 && head_of(1) == 2 && head_of(3) == 2, "R9", "heads after round robin",
        64'(sq_head), {48'd0, 4'd2, 4'd1, 4'd2, 4'd3});
    gap_en = 1'b0;
  endtask

  initial begin
    qbase[0] = 64'h0000_0001_0000_0000;
    qbase[1] = 64'h0000_0000_2000_0040;
    qbase[2] = 64'h0000_0003_4000_0400;
    qbase[3] = 64'h0000_0000_0123_4000;
    qsize[0] = 8; qsize[1] = 8; qsize[2] = 4; qsize[3] = 6;
    for (int q = 0; q < NQ; q++) begin
      cfg_sq_base[q*64 +: 64] = qbase[q];
      cfg_sq_size[q*IW +: IW] = IW'(qsize[q]);
    end
    t_reset();
    t_single();
    t_bad();
    t_wrap();
    t_rr();
    repeat (5) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule